// File: doc/BRIEF.md
# Reciprocal Square Root Estimate Unit

This unit produces an 8-bit-accurate estimate of 1/sqrt(x). It takes a half precision or single precision floating-point operand, or an unsigned fixed-point operand in which bit 31 has weight one half. Software uses the estimate as a seed for Newton-Raphson refinement. Each request carries the operand, a format select, a flush-to-zero enable and a default-NaN enable. The unit answers with a result word and two exception flags.

The core of the estimate is an integer search. The operand's leading significand bits are turned into a 9-bit kernel input. The search then counts upward from 512, one step per clock, to find the largest integer whose square, multiplied by the scaled input, stays below 2^28. Because the search takes a variable number of cycles, a request is issued with a one-cycle `start` and is answered with a one-cycle `done`. Special operands (zero, negative, infinity, NaN, saturating fixed-point inputs) skip the search.

Top module: `rsqrt_est_unit`

## Requirements
- R1: With `fmt` = 2 or 3 (unsigned fixed point), an operand with bits [31:30] both zero returns 0xFFFFFFFF. Any other operand returns the 9-bit kernel estimate of operand[31:23] in result[31:23], with zeros below. Both flags are 0.
- R2: Kernel: the input a (128..511) becomes 2a+1 if a < 256; otherwise a with bit 0 cleared, plus one, then doubled. Starting at b = 512, b is incremented while that value times (b+1)^2 is below 2^28. The estimate is (b+1)/2 and always lies in 256..511.
- R3: Half precision (`fmt` = 0, operand[15:0]), positive finite nonzero input: result[15:0] = {0, E, est[7:0], 2'b00}, where E = (44 - e)/2 and e is the (normalised) exponent. result[31:16] = 0 and the flags are 0. An odd e feeds the kernel with {01, top 7 fraction bits}; an even e feeds it with {1, top 8 fraction bits}.
- R4: Single precision (`fmt` = 1): the same as R3 with E = (380 - e)/2, an 8-bit exponent field and 15 trailing zero bits.
- R5: A subnormal input with flush-to-zero off is normalised first. The fraction is shifted left until its top bit is set, and e is decremented once per shift starting from 0. Then that bit is dropped and the fraction is shifted once more.
- R6: A zero input (either sign) returns infinity of the same sign and sets the divide-by-zero flag, flags[1]. The two flags are never both set.
- R7: A negative, nonzero, non-NaN input returns the default NaN and sets the invalid flag, flags[0]. The default NaN is 0x7E00 for half and 0x7FC00000 for single.
- R8: Positive infinity returns +0 with no flags.
- R9: A NaN input with the fraction's top bit at 0 (signalling) sets invalid and returns the operand with that bit set. A quiet NaN is returned unchanged with no flags. With `dnan_en` = 1 the result is the default NaN in both cases.
- R10: With `ftz_en` = 1, a subnormal input is treated as a zero of the same sign (R6 applies).
- R11: `start` is taken only when the unit is idle. `done` is high for exactly one cycle. `result` and `flags` hold their value from `done` until the next accepted request. A special operand gives `done` two cycles after the `start` cycle.
- R12: A searched operand gives `done` 3 + n cycles after the `start` cycle, where n is the number of increments in R2. n never exceeds 511, and b never reaches 1024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken when idle |
| fmt | input | 2 | 0 half, 1 single, 2/3 unsigned fixed point |
| operand | input | 32 | Operand (half uses bits [15:0]) |
| ftz_en | input | 1 | Flush subnormal inputs to zero |
| dnan_en | input | 1 | Replace NaN results by the default NaN |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Estimate, held until the next request |
| flags | output | 2 | [1] divide-by-zero, [0] invalid |

## Verification
The assertions rely on the kernel being loaded only with an input of 128 or more; the unit guarantees this because fixed-point operands with both top bits clear are diverted to saturation. They also rely on `start` being ignored while busy, so that the latched operand cannot change in the middle of a search. The stimulus drives every legal kernel input through the fixed-point mode and sweeps half and single exponents, each with several fractions. It also covers subnormals, signed zeros, infinities, both NaN kinds, and one start pulse issued during a search. All inputs change half a cycle away from the sampling edge.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int KIN_W = 9;
  localparam int LIMIT_LOG2 = 28;

  localparam logic [1:0] FMT_HALF   = 2'd0;
  localparam logic [1:0] FMT_SINGLE = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } rsq_state_e;
endpackage

// File: rtl/rsq_kernel.sv
module rsq_kernel
  import rsq_pkg::*;
#(
  parameter int IN_W     = KIN_W,
  parameter int LIM_LOG2 = LIMIT_LOG2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic [IN_W-1:0] kin,
  output logic            hit,
  output logic [IN_W-1:0] est
);
  localparam int A2_W   = IN_W + 1;
  localparam int B_W    = IN_W + 2;
  localparam int PROD_W = A2_W + 2 * B_W;
  localparam logic [B_W-1:0] B_INIT = B_W'(1) << IN_W;

  logic [A2_W-1:0]   a2_q, a2_d;
  logic [B_W-1:0]    b_q, b_d;
  logic [B_W-1:0]    bp1, half_b;
  logic [2*B_W-1:0]  sq;
  logic [PROD_W-1:0] prod;

  always_comb begin
    a2_d = a2_q;
    b_d  = b_q;
    if (load) begin
      a2_d = kin[IN_W-1] ? {kin[IN_W-1:1], 1'b1, 1'b0}
                         : {1'b0, kin[IN_W-2:0], 1'b1};
      b_d  = B_INIT;
    end else if (step) begin
      b_d = b_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a2_q <= '0;
      b_q  <= B_INIT;
    end else begin
      a2_q <= a2_d;
      b_q  <= b_d;
    end
  end

  always_comb begin
    bp1    = b_q + 1'b1;
    sq     = (2*B_W)'(bp1) * (2*B_W)'(bp1);
    prod   = PROD_W'(a2_q) * PROD_W'(sq);
    hit    = prod >= (PROD_W'(1) << LIM_LOG2);
    half_b = bp1 >> 1;
    est    = IN_W'(half_b);
  end

  // R12
  srch_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !b_q[B_W-1]);

  // R12
  step_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !hit);

  // R2
  est_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (est[IN_W-1] && half_b[B_W-1:IN_W] == '0));
endmodule

// File: rtl/rsq_fp_path.sv
module rsq_fp_path
  import rsq_pkg::*;
#(
  parameter int EW     = 5,
  parameter int FW     = 10,
  parameter int OFFSET = 44
) (
  input  logic [EW+FW:0]   val,
  input  logic             ftz,
  input  logic             dnan,
  input  logic [7:0]       est,
  output logic             special,
  output logic [EW+FW:0]   spec_val,
  output logic [1:0]       spec_flg,
  output logic [KIN_W-1:0] kin,
  output logic [EW+FW:0]   packed_val
);
  localparam int LZ_W = $clog2(FW + 1);
  localparam int ESW  = EW + 2;
  localparam logic [EW+FW:0] DEF_NAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

  logic          sgn;
  logic [EW-1:0] e;
  logic [FW-1:0] f, f_eff, nf;
  logic [LZ_W-1:0] lz;
  logic          found;
  logic signed [ESW-1:0] exp_n;
  logic [15:0]   ediff;
  logic [EW-1:0] res_exp;
  logic [7:0]    top8;
  logic [6:0]    top7;
  logic          is_nan, is_inf, is_zero;

  always_comb begin
    sgn   = val[EW+FW];
    e     = val[EW+FW-1:FW];
    f     = val[FW-1:0];
    f_eff = (ftz && e == '0) ? '0 : f;
    lz    = '0;
    found = 1'b0;
    for (int i = FW - 1; i >= 0; i--) begin
      if (!found) begin
        if (f_eff[i]) found = 1'b1;
        else          lz = LZ_W'(lz + 1'b1);
      end
    end
    exp_n   = (e == '0) ? -$signed(ESW'(lz)) : $signed(ESW'(e));
    nf      = (e == '0) ? FW'(f_eff << (lz + 1'b1)) : f_eff;
    top8    = 8'(nf >> (FW - 8));
    top7    = 7'(nf >> (FW - 7));
    kin     = exp_n[0] ? {2'b01, top7} : {1'b1, top8};
    ediff   = 16'(OFFSET) - 16'(exp_n);
    res_exp = EW'(ediff >> 1);
    packed_val = {1'b0, res_exp, est, {(FW-8){1'b0}}};
  end

  always_comb begin
    is_nan  = (e == '1) && (f != '0);
    is_inf  = (e == '1) && (f == '0);
    is_zero = (e == '0) && (f_eff == '0);
    special  = 1'b1;
    spec_val = '0;
    spec_flg = 2'b00;
    if (is_nan) begin
      spec_val = dnan ? DEF_NAN : (val | (EW+FW+1)'(1) << (FW - 1));
      spec_flg = {1'b0, ~f[FW-1]};
    end else if (is_zero) begin
      spec_val = {sgn, {EW{1'b1}}, {FW{1'b0}}};
      spec_flg = 2'b10;
    end else if (sgn) begin
      spec_val = DEF_NAN;
      spec_flg = 2'b01;
    end else if (is_inf) begin
      spec_val = '0;
    end else begin
      special = 1'b0;
    end
  end
endmodule

// File: rtl/rsqrt_est_unit.sv
module rsqrt_est_unit
  import rsq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  fmt,
  input  logic [31:0] operand,
  input  logic        ftz_en,
  input  logic        dnan_en,
  output logic        done,
  output logic [31:0] result,
  output logic [1:0]  flags
);
  rsq_state_e  state_q, state_d;
  logic [31:0] op_q, res_q, res_d;
  logic [1:0]  fmt_q, flg_q, flg_d;
  logic        ftz_q, dnan_q, cap;

  logic             k_load, k_step, k_hit;
  logic [KIN_W-1:0] k_est;

  logic             h_special, s_special;
  logic [15:0]      h_spec, h_pk;
  logic [31:0]      s_spec, s_pk;
  logic [1:0]       h_flg, s_flg;
  logic [KIN_W-1:0] h_kin, s_kin;

  logic             sel_special;
  logic [31:0]      sel_spec, sel_pk;
  logic [1:0]       sel_flg;
  logic [KIN_W-1:0] sel_kin;

  rsq_fp_path #(.EW(5), .FW(10), .OFFSET(44)) half_i (
    .val(op_q[15:0]), .ftz(ftz_q), .dnan(dnan_q), .est(k_est[7:0]),
    .special(h_special), .spec_val(h_spec), .spec_flg(h_flg),
    .kin(h_kin), .packed_val(h_pk));

  rsq_fp_path #(.EW(8), .FW(23), .OFFSET(380)) single_i (
    .val(op_q), .ftz(ftz_q), .dnan(dnan_q), .est(k_est[7:0]),
    .special(s_special), .spec_val(s_spec), .spec_flg(s_flg),
    .kin(s_kin), .packed_val(s_pk));

  rsq_kernel #(.IN_W(KIN_W), .LIM_LOG2(LIMIT_LOG2)) kern_i (
    .clk(clk), .rst_n(rst_n), .load(k_load), .step(k_step),
    .kin(sel_kin), .hit(k_hit), .est(k_est));

  always_comb begin
    unique case (fmt_q)
      FMT_HALF: begin
        sel_special = h_special;
        sel_spec    = {16'h0, h_spec};
        sel_flg     = h_flg;
        sel_kin     = h_kin;
        sel_pk      = {16'h0, h_pk};
      end
      FMT_SINGLE: begin
        sel_special = s_special;
        sel_spec    = s_spec;
        sel_flg     = s_flg;
        sel_kin     = s_kin;
        sel_pk      = s_pk;
      end
      default: begin
        sel_special = (op_q[31:30] == 2'b00);
        sel_spec    = 32'hFFFF_FFFF;
        sel_flg     = 2'b00;
        sel_kin     = op_q[31:23];
        sel_pk      = {k_est, 23'h0};
      end
    endcase
  end

  assign cap = (state_q == ST_IDLE) && start;

  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    flg_d   = flg_q;
    k_load  = 1'b0;
    k_step  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_LOAD;
      ST_LOAD: begin
        if (sel_special) begin
          res_d   = sel_spec;
          flg_d   = sel_flg;
          state_d = ST_DONE;
        end else begin
          k_load  = 1'b1;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (k_hit) begin
          res_d   = sel_pk;
          flg_d   = 2'b00;
          state_d = ST_DONE;
        end else begin
          k_step = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      res_q   <= '0;
      flg_q   <= '0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      flg_q   <= flg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      fmt_q  <= '0;
      ftz_q  <= 1'b0;
      dnan_q <= 1'b0;
    end else if (cap) begin
      op_q   <= operand;
      fmt_q  <= fmt;
      ftz_q  <= ftz_en;
      dnan_q <= dnan_en;
    end
  end

  assign done   = (state_q == ST_DONE);
  assign result = res_q;
  assign flags  = flg_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE || state_q == ST_DONE) |=> ($stable(result) && $stable(flags)));

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags));

  // R1
  ufix_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD && fmt_q[1] && op_q[31:30] == 2'b00)
      |=> (result == 32'hFFFF_FFFF && flags == 2'b00));
endmodule

// File: tb/rsqrt_est_unit_tb.sv
`timescale 1ns/1ps
module rsqrt_est_unit_tb_top;
  logic        clk, rst_n, start, ftz_en, dnan_en;
  logic [1:0]  fmt;
  logic [31:0] operand;
  logic        done;
  logic [31:0] result;
  logic [1:0]  flags;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  rsqrt_est_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fmt(fmt), .operand(operand),
    .ftz_en(ftz_en), .dnan_en(dnan_en), .done(done), .result(result),
    .flags(flags));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected below 190000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [33:0] act,
                     input logic [33:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Kernel per R2: returns estimate and the number of increments.
  function automatic void kern(input int a, output int est, output int steps);
    longint a2, b;
    if (a < 256) a2 = 2 * a + 1;
    else         a2 = ((a / 2) * 2 + 1) * 2;
    b = 512;
    while (a2 * (b + 1) * (b + 1) < (longint'(1) << 28)) b++;
    est   = int'((b + 1) / 2);
    steps = int'(b - 512);
  endfunction

  // Floating-point model per R3..R10.
  function automatic void fmodel(input longint v, input int ew, input int fw,
      input int off, input bit z, input bit d,
      output logic [31:0] r, output logic [1:0] fl);
    longint emax, e, f, sg, defn, res;
    int a, est, steps;
    emax = (longint'(1) << ew) - 1;
    sg = (v >> (ew + fw)) & 1;
    e  = (v >> fw) & emax;
    f  = v & ((longint'(1) << fw) - 1);
    defn = (emax << fw) | (longint'(1) << (fw - 1));
    fl = 2'b00;
    if (z && e == 0) f = 0;
    if (e == emax && f != 0) begin
      if (((f >> (fw - 1)) & 1) == 0) fl = 2'b01;
      res = d ? defn : (v | (longint'(1) << (fw - 1)));
    end else if (e == 0 && f == 0) begin
      res = (sg << (ew + fw)) | (emax << fw);
      fl = 2'b10;
    end else if (sg == 1) begin
      res = defn; fl = 2'b01;
    end else if (e == emax) begin
      res = 0;
    end else begin
      if (e == 0) begin
        while (((f >> (fw - 1)) & 1) == 0) begin f = f << 1; e = e - 1; end
        f = (f << 1) & ((longint'(1) << fw) - 1);
      end
      if ((e & 1) != 0) a = 128 + int'(f >> (fw - 7));
      else              a = 256 + int'(f >> (fw - 8));
      kern(a, est, steps);
      res = (((off - e) / 2) << fw) | ((longint'(est) & 255) << (fw - 8));
    end
    r = 32'(res);
  endfunction

  task automatic run_op(input logic [31:0] op, input logic [1:0] f,
      input bit z, input bit d, output logic [31:0] r, output logic [1:0] fl,
      output int lat);
    @(negedge clk);
    operand = op; fmt = f; ftz_en = z; dnan_en = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1;
    while (!done && lat < 1100) begin @(negedge clk); lat++; end
    r = result; fl = flags;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R11: got no done expected done within 1100 cycles");
    end
  endtask

  task automatic do_fp(input string req, input logic [31:0] op, input bit single,
                       input bit z, input bit d);
    logic [31:0] r, er;
    logic [1:0]  fl, efl;
    int lat;
    if (single) fmodel(longint'(op), 8, 23, 380, z, d, er, efl);
    else        fmodel(longint'(op[15:0]), 5, 10, 44, z, d, er, efl);
    run_op(single ? op : {16'h0, op[15:0]}, single ? 2'd1 : 2'd0, z, d, r, fl, lat);
    chk({fl, r} == {efl, er}, req, {fl, r}, {efl, er});
  endtask

  initial begin
    logic [31:0] r, r0;
    logic [1:0]  fl;
    int lat, est, steps;
    rst_n = 1'b0; start = 1'b0; fmt = 2'd0; operand = '0; ftz_en = 1'b0; dnan_en = 1'b0;
    repeat (3) @(negedge clk);
    // reset state
    chk(done == 1'b0 && result == 32'h0 && flags == 2'b00, "R11 reset",
        {flags, result}, 34'h0);
    rst_n = 1'b1;

    // R1 R2 R12: every kernel input through the fixed-point mode
    for (int a = 128; a < 512; a++) begin
      kern(a, est, steps);
      run_op({a[8:0], 23'h2A5A5A}, (a % 2 == 0) ? 2'd2 : 2'd3, 1'b0, 1'b0, r, fl, lat);
      chk({fl, r} == {2'b00, est[8:0], 23'h0}, "R1 R2 ufix", {fl, r},
          {2'b00, est[8:0], 23'h0});
      chk(lat == 3 + steps && steps <= 511, "R12 latency", 34'(lat), 34'(3 + steps));
    end
    run_op(32'h3FFF_FFFF, 2'd2, 1'b0, 1'b0, r, fl, lat);
    chk({fl, r} == {2'b00, 32'hFFFF_FFFF}, "R1 saturate", {fl, r}, {2'b00, 32'hFFFF_FFFF});
    chk(lat == 2, "R11 special latency", 34'(lat), 34'd2);

    // R3 half normals
    for (int e = 1; e < 31; e++) begin
      do_fp("R3 half", {16'h0, 1'b0, e[4:0], 10'h000}, 1'b0, 1'b0, 1'b0);
      do_fp("R3 half", {16'h0, 1'b0, e[4:0], 10'h3FF}, 1'b0, 1'b0, 1'b0);
      do_fp("R3 half", {16'h0, 1'b0, e[4:0], 10'h155}, 1'b0, 1'b0, 1'b0);
    end
    // R5 half subnormals
    for (int k = 0; k < 10; k++)
      do_fp("R5 half subnormal", {16'h0, 6'h00, 10'(1 << k)}, 1'b0, 1'b0, 1'b0);
    do_fp("R5 half subnormal", 32'h0000_03FF, 1'b0, 1'b0, 1'b0);

    // R4 single normals
    for (int e = 1; e < 255; e += 12) begin
      do_fp("R4 single", {1'b0, e[7:0], 23'h000000}, 1'b1, 1'b0, 1'b0);
      do_fp("R4 single", {1'b0, e[7:0], 23'h7FFFFF}, 1'b1, 1'b0, 1'b0);
    end
    do_fp("R4 single", 32'h3F80_0000, 1'b1, 1'b0, 1'b0);
    do_fp("R5 single subnormal", 32'h0000_0001, 1'b1, 1'b0, 1'b0);
    do_fp("R5 single subnormal", 32'h0000_0020, 1'b1, 1'b0, 1'b0);
    do_fp("R5 single subnormal", 32'h0040_0000, 1'b1, 1'b0, 1'b0);

    // R6 zeros
    do_fp("R6 zero", 32'h0000_0000, 1'b0, 1'b0, 1'b0);
    do_fp("R6 zero", 32'h0000_8000, 1'b0, 1'b0, 1'b0);
    do_fp("R6 zero", 32'h8000_0000, 1'b1, 1'b0, 1'b0);
    // R7 negatives
    do_fp("R7 negative", 32'h0000_BC00, 1'b0, 1'b0, 1'b0);
    do_fp("R7 negative", 32'hBF80_0000, 1'b1, 1'b0, 1'b0);
    do_fp("R7 negative", 32'hFF80_0000, 1'b1, 1'b0, 1'b0);
    do_fp("R7 negative", 32'h0000_8001, 1'b0, 1'b0, 1'b0);
    // R8 +inf
    do_fp("R8 inf", 32'h0000_7C00, 1'b0, 1'b0, 1'b0);
    do_fp("R8 inf", 32'h7F80_0000, 1'b1, 1'b0, 1'b0);
    // R9 NaNs
    do_fp("R9 snan", 32'h0000_7C01, 1'b0, 1'b0, 1'b0);
    do_fp("R9 qnan", 32'h0000_FE12, 1'b0, 1'b0, 1'b0);
    do_fp("R9 snan", 32'hFF80_0005, 1'b1, 1'b0, 1'b0);
    do_fp("R9 qnan", 32'h7FC0_1234, 1'b1, 1'b0, 1'b0);
    do_fp("R9 dnan", 32'h0000_7C01, 1'b0, 1'b0, 1'b1);
    do_fp("R9 dnan", 32'hFFC0_0001, 1'b1, 1'b0, 1'b1);
    // R10 flush to zero
    do_fp("R10 ftz", 32'h0000_0155, 1'b0, 1'b1, 1'b0);
    do_fp("R10 ftz", 32'h8000_0020, 1'b1, 1'b1, 1'b0);
    do_fp("R10 ftz normal", 32'h3F80_0000, 1'b1, 1'b1, 1'b0);

    // R11: start while busy is ignored, done is one pulse, result holds
    kern(128, est, steps);
    @(negedge clk);
    operand = 32'h4000_0000; fmt = 2'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    operand = 32'h0000_0000; fmt = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 0;
    while (!done && lat < 1100) begin @(negedge clk); lat++; end
    r0 = result;
    chk({flags, result} == {2'b00, est[8:0], 23'h0}, "R11 busy start ignored",
        {flags, result}, {2'b00, est[8:0], 23'h0});
    @(negedge clk);
    chk(done == 1'b0, "R11 done one cycle", 34'(done), 34'd0);
    repeat (4) @(negedge clk);
    chk(done == 1'b0 && result == r0 && flags == 2'b00, "R11 hold",
        {flags, result}, {2'b00, r0});

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule